// File: doc/BRIEF.md
# PDM Microphone Clock Generator

This block drives the bit clock of one or two digital pulse-density microphones that share one data wire, and it samples that wire for each of two channels. The clock comes from dividing the fast IO clock by a programmable integer. The divider code is the divisor minus two, so the fastest microphone clock is half the IO clock. When the divisor is odd, the low phase is one IO cycle longer than the high phase. The clock is held low while neither channel is enabled. When a channel is enabled, the clock begins at the start of a low phase.

The two microphones drive the shared wire on opposite clock phases, so channel A samples on one clock edge and channel B samples on the other. An edge-invert input picks which edge belongs to channel A. Setting it swaps the channels, so a mono microphone on the right position can be routed through channel A. A skew field delays the sampling point by a number of IO cycles after the selected edge. Each channel returns the sampled bit together with a one-cycle valid strobe. Software chooses the divider so that the sample rate and the microphone duty-cycle limits are met.

Top module: `pdm_clkgen`

## Requirements
- R1: With divider code D, the microphone clock period is N = D + 2 IO cycles, measured from one rising edge to the next; D = 0 gives N = 2.
- R2: Each period has a low phase of N - floor(N/2) IO cycles and a high phase of floor(N/2) IO cycles, so an odd N makes the low phase one cycle longer.
- R3: While en_a and en_b are both low, mic_clk is low from the next cycle on, and it stays low.
- R4: If an enable rises in cycle c0 while the clock is idle, the first rising edge of mic_clk appears in cycle c0 + N - floor(N/2).
- R5: With edge_inv = 0, channel A samples on the rising edge of mic_clk and channel B samples on the falling edge.
- R6: With edge_inv = 1, channel A samples on the falling edge and channel B samples on the rising edge.
- R7: If mic_clk changes in cycle E and the skew is S, the channel samples pdm_din as it stands during cycle E + S. Its bit output and its valid strobe show the result in cycle E + S + 1. S must be below floor(N/2).
- R8: A channel whose enable is low gives no valid strobe, and its bit output holds its last value while the other channel runs.
- R9: Each valid strobe lasts exactly one cycle, and an enabled channel gives one strobe per microphone clock period.
- R10: An asynchronous reset (rst_n low) drives mic_clk, both bit outputs and both strobes to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_io | input | 1 | Fast IO clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| div_code | input | DIV_W | Clock divisor minus two |
| edge_inv | input | 1 | 0: A samples on the rising edge; 1: A samples on the falling edge |
| skew | input | SKEW_W | Sampling delay after the edge, in IO cycles |
| en_a | input | 1 | Channel A sampling enable |
| en_b | input | 1 | Channel B sampling enable |
| pdm_din | input | 1 | Shared microphone data wire |
| mic_clk | output | 1 | Microphone bit clock |
| a_bit | output | 1 | Last bit sampled for channel A |
| a_vld | output | 1 | One-cycle strobe for a new a_bit |
| b_bit | output | 1 | Last bit sampled for channel B |
| b_vld | output | 1 | One-cycle strobe for a new b_bit |

## Verification
The bench measures every high phase, low phase and period for divisors 2 through 9. Two faults show up in these measurements: a divider that omits the offset of two gives a period one or two cycles short, and a wrong split for odd divisors puts the extra cycle in the high phase. The bench pins the first rising edge after enable to an exact cycle, which catches a clock that restarts mid-phase or starts high. Channel routing is checked with edge_inv both clear and set. The sampled bit is compared with a pseudo-random data history at the exact cycle the skew implies, so a swapped edge, an off-by-one skew count or a missing pipeline stage returns the wrong bit or a strobe in the wrong cycle. The bench also runs with one channel disabled and applies reset while the clock is running, to catch strobes leaking from a disabled channel and state that survives reset.

// File: rtl/pdm_clkgen_pkg.sv
package pdm_clkgen_pkg;

   // Edge events of the microphone clock, aligned with the cycle the clock changes
   typedef struct packed {
      logic rise;
      logic fall;
   } edge_ev_t;

   // Which clock edge a lane samples on
   typedef enum logic {
      CAP_ON_RISE = 1'b0,
      CAP_ON_FALL = 1'b1
   } cap_edge_e;

endpackage

// File: rtl/pdm_phase_ctr.sv
module pdm_phase_ctr
   import pdm_clkgen_pkg::*;
#(
   parameter int DIV_W = 8
) (
   input  logic             clk_io,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div_code,
   output logic             clk_out,
   output edge_ev_t         ev
);
   localparam int CNT_W = DIV_W + 1;

   logic [CNT_W-1:0] div_n;
   logic [CNT_W-1:0] low_len;
   logic [CNT_W-1:0] last_idx;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_nx;
   logic             hi_nx;

   // Divisor is the code plus two; the low phase takes the larger half
   assign div_n    = {1'b0, div_code} + CNT_W'(2);
   assign low_len  = div_n - (div_n >> 1);
   assign last_idx = div_n - CNT_W'(1);
   assign cnt_nx   = (cnt_q >= last_idx) ? '0 : cnt_q + CNT_W'(1);
   assign hi_nx    = (cnt_nx >= low_len);

   always_ff @(posedge clk_io or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         clk_out <= 1'b0;
         ev      <= '0;
      end else if (!run) begin
         cnt_q   <= '0;
         clk_out <= 1'b0;
         ev.rise <= 1'b0;
         ev.fall <= clk_out;
      end else begin
         cnt_q   <= cnt_nx;
         clk_out <= hi_nx;
         ev.rise <= !clk_out && hi_nx;
         ev.fall <= clk_out && !hi_nx;
      end
   end

endmodule

// File: rtl/pdm_capture_lane.sv
module pdm_capture_lane #(
   parameter int SKEW_W = 4
) (
   input  logic              clk_io,
   input  logic              rst_n,
   input  logic              en,
   input  logic              strobe,
   input  logic [SKEW_W-1:0] skew,
   input  logic              din,
   output logic              bit_q,
   output logic              vld_q
);
   logic              pend_q;
   logic [SKEW_W-1:0] wait_q;

   always_ff @(posedge clk_io or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         wait_q <= '0;
         bit_q  <= 1'b0;
         vld_q  <= 1'b0;
      end else begin
         vld_q <= 1'b0;
         if (!en) begin
            pend_q <= 1'b0;
            wait_q <= '0;
         end else if (strobe && (skew == '0)) begin
            bit_q  <= din;
            vld_q  <= 1'b1;
            pend_q <= 1'b0;
         end else if (strobe) begin
            pend_q <= 1'b1;
            wait_q <= skew - SKEW_W'(1);
         end else if (pend_q) begin
            if (wait_q == '0) begin
               bit_q  <= din;
               vld_q  <= 1'b1;
               pend_q <= 1'b0;
            end else begin
               wait_q <= wait_q - SKEW_W'(1);
            end
         end
      end
   end

endmodule

// File: rtl/pdm_clkgen.sv
module pdm_clkgen
   import pdm_clkgen_pkg::*;
#(
   parameter int DIV_W  = 8,
   parameter int SKEW_W = 4
) (
   input  logic              clk_io,
   input  logic              rst_n,
   input  logic [DIV_W-1:0]  div_code,
   input  logic              edge_inv,
   input  logic [SKEW_W-1:0] skew,
   input  logic              en_a,
   input  logic              en_b,
   input  logic              pdm_din,
   output logic              mic_clk,
   output logic              a_bit,
   output logic              a_vld,
   output logic              b_bit,
   output logic              b_vld
);
   localparam int LANES = 2;

   if (DIV_W < 1 || DIV_W > 16) begin : g_bad_div
      $error("pdm_clkgen: DIV_W out of range");
   end
   if (SKEW_W < 1 || SKEW_W > 8) begin : g_bad_skew
      $error("pdm_clkgen: SKEW_W out of range");
   end

   edge_ev_t   ev;
   logic       run;
   cap_edge_e  lane_edge [LANES];
   logic       lane_en   [LANES];
   logic       lane_bit  [LANES];
   logic       lane_vld  [LANES];

   assign run          = en_a | en_b;
   assign lane_edge[0] = cap_edge_e'(edge_inv);
   assign lane_edge[1] = cap_edge_e'(~edge_inv);
   assign lane_en[0]   = en_a;
   assign lane_en[1]   = en_b;

   pdm_phase_ctr #(.DIV_W(DIV_W)) u_phase (
      .clk_io  (clk_io),
      .rst_n   (rst_n),
      .run     (run),
      .div_code(div_code),
      .clk_out (mic_clk),
      .ev      (ev)
   );

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic strobe;
      assign strobe = (lane_edge[g] == CAP_ON_RISE) ? ev.rise : ev.fall;

      pdm_capture_lane #(.SKEW_W(SKEW_W)) u_lane (
         .clk_io(clk_io),
         .rst_n (rst_n),
         .en    (lane_en[g]),
         .strobe(strobe),
         .skew  (skew),
         .din   (pdm_din),
         .bit_q (lane_bit[g]),
         .vld_q (lane_vld[g])
      );
   end

   assign a_bit = lane_bit[0];
   assign a_vld = lane_vld[0];
   assign b_bit = lane_bit[1];
   assign b_vld = lane_vld[1];

endmodule

// File: rtl/pdm_clkgen_chk.sv
module pdm_clkgen_chk #(
   parameter int DIV_W  = 8,
   parameter int SKEW_W = 4
) (
   input logic             clk_io,
   input logic             rst_n,
   input logic [DIV_W-1:0] div_code,
   input logic             en_a,
   input logic             en_b,
   input logic             mic_clk,
   input logic             a_vld,
   input logic             b_vld
);
   logic [DIV_W:0] hi_run;
   logic [DIV_W:0] half_w;

   assign half_w = ({1'b0, div_code} + (DIV_W+1)'(2)) >> 1;

   always_ff @(posedge clk_io or negedge rst_n) begin
      if (!rst_n)       hi_run <= '0;
      else if (mic_clk) hi_run <= hi_run + (DIV_W+1)'(1);
      else              hi_run <= '0;
   end

   // R2: a high phase ended by the divider lasts floor(N/2) cycles
   a_r2_high_len: assert property (@(posedge clk_io) disable iff (!rst_n)
      ($fell(mic_clk) && $past(en_a | en_b) && $stable(div_code)) |-> (hi_run == half_w));

   // R3: no enable, clock low next cycle
   a_r3_idle_low: assert property (@(posedge clk_io) disable iff (!rst_n)
      !(en_a | en_b) |=> !mic_clk);

   // R8: disabled lanes give no strobe
   a_r8_lane_a_off: assert property (@(posedge clk_io) disable iff (!rst_n)
      !en_a |=> !a_vld);
   a_r8_lane_b_off: assert property (@(posedge clk_io) disable iff (!rst_n)
      !en_b |=> !b_vld);

   // R9: strobes are single-cycle
   a_r9_pulse_a: assert property (@(posedge clk_io) disable iff (!rst_n)
      a_vld |=> !a_vld);
   a_r9_pulse_b: assert property (@(posedge clk_io) disable iff (!rst_n)
      b_vld |=> !b_vld);

endmodule

bind pdm_clkgen pdm_clkgen_chk #(.DIV_W(DIV_W), .SKEW_W(SKEW_W)) u_chk (
   .clk_io  (clk_io),
   .rst_n   (rst_n),
   .div_code(div_code),
   .en_a    (en_a),
   .en_b    (en_b),
   .mic_clk (mic_clk),
   .a_vld   (a_vld),
   .b_vld   (b_vld)
);

// File: tb/pdm_clkgen_test.sv
module pdm_clkgen_test;
   logic       clk = 1'b0;
   logic       rst_n;
   logic [7:0] div_code;
   logic       edge_inv;
   logic [3:0] skew;
   logic       en_a, en_b, pdm_din;
   logic       mic_clk, a_bit, a_vld, b_bit, b_vld;

   always #5 clk = ~clk;

   pdm_clkgen #(.DIV_W(8), .SKEW_W(4)) uut (
      .clk_io(clk), .rst_n(rst_n), .div_code(div_code), .edge_inv(edge_inv),
      .skew(skew), .en_a(en_a), .en_b(en_b), .pdm_din(pdm_din),
      .mic_clk(mic_clk), .a_bit(a_bit), .a_vld(a_vld), .b_bit(b_bit), .b_vld(b_vld)
   );

   // {div_code, edge_inv, skew}
   localparam int NVEC = 10;
   localparam logic [12:0] VEC [NVEC] = '{
      {8'd0, 1'b0, 4'd0}, {8'd1, 1'b1, 4'd0}, {8'd2, 1'b0, 4'd1}, {8'd3, 1'b1, 4'd1},
      {8'd4, 1'b0, 4'd2}, {8'd5, 1'b1, 4'd2}, {8'd6, 1'b0, 4'd3}, {8'd7, 1'b1, 4'd3},
      {8'd7, 1'b0, 4'd0}, {8'd2, 1'b1, 4'd0}
   };

   int checks = 0, fails = 0;
   bit done = 0;

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   int   cyc = 0, c0 = 0;
   bit   mon_on = 0, arm = 0, prev_clk = 0, seen_rise = 0;
   int   last_rise = 0, last_fall = 0;
   int   due_a = -1, idx_a = 0, due_b = -1, idx_b = 0;
   int   n_cur = 2, low_cur = 1, high_cur = 1;
   int   a_cnt = 0, b_cnt = 0;
   bit   hist [32];
   logic [15:0] lfsr = 16'hACE1;

   always @(negedge clk) begin
      cyc++;
      if (arm) begin c0 = cyc; arm = 0; end
      if (a_vld === 1'b1) a_cnt++;
      if (b_vld === 1'b1) b_cnt++;
      if (mon_on) begin
         if (cyc == due_a) begin
            chk(a_vld === 1'b1, "R7", "lane A strobe cycle", int'(a_vld), 1);
            chk(a_bit === hist[idx_a % 32], edge_inv ? "R6" : "R5", "lane A bit",
                int'(a_bit), int'(hist[idx_a % 32]));
            due_a = -1;
         end else if (a_vld !== 1'b0) chk(1'b0, "R9", "lane A extra strobe", int'(a_vld), 0);
         if (cyc == due_b) begin
            chk(b_vld === 1'b1, "R7", "lane B strobe cycle", int'(b_vld), 1);
            chk(b_bit === hist[idx_b % 32], edge_inv ? "R6" : "R5", "lane B bit",
                int'(b_bit), int'(hist[idx_b % 32]));
            due_b = -1;
         end else if (b_vld !== 1'b0) chk(1'b0, "R9", "lane B extra strobe", int'(b_vld), 0);

         if (!prev_clk && mic_clk) begin
            if (!seen_rise) chk(cyc == c0 + low_cur, "R4", "first rise offset", cyc - c0, low_cur);
            else begin
               chk(cyc - last_rise == n_cur, "R1", "period", cyc - last_rise, n_cur);
               chk(cyc - last_fall == low_cur, "R2", "low phase", cyc - last_fall, low_cur);
            end
            seen_rise = 1; last_rise = cyc;
            if (!edge_inv && en_a) begin due_a = cyc + skew + 1; idx_a = cyc + skew; end
            if (edge_inv && en_b)  begin due_b = cyc + skew + 1; idx_b = cyc + skew; end
         end
         if (prev_clk && !mic_clk) begin
            if (seen_rise) chk(cyc - last_rise == high_cur, "R2", "high phase", cyc - last_rise, high_cur);
            last_fall = cyc;
            if (edge_inv && en_a)  begin due_a = cyc + skew + 1; idx_a = cyc + skew; end
            if (!edge_inv && en_b) begin due_b = cyc + skew + 1; idx_b = cyc + skew; end
         end
      end
      prev_clk = mic_clk;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      pdm_din = lfsr[0];
      hist[cyc % 32] = lfsr[0];
   end

   task automatic start(input int code, input bit inv, input int sk, input bit ea, input bit eb);
      @(posedge clk); #1;
      en_a = 0; en_b = 0; mon_on = 0;
      repeat (3) @(posedge clk);
      #1;
      div_code = 8'(code); edge_inv = inv; skew = 4'(sk);
      n_cur = code + 2; high_cur = n_cur / 2; low_cur = n_cur - high_cur;
      seen_rise = 0; due_a = -1; due_b = -1;
      en_a = ea; en_b = eb; arm = 1; mon_on = 1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      chk(1'b0, "watchdog", "run timed out", 0, 1);
      finish_run();
   end

   initial begin
      rst_n = 0; div_code = 0; edge_inv = 0; skew = 0; en_a = 0; en_b = 0; pdm_din = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R10: reset state
      chk(mic_clk === 1'b0 && a_vld === 1'b0 && b_vld === 1'b0, "R10", "outputs in reset",
          int'({mic_clk, a_vld, b_vld}), 0);
      chk(a_bit === 1'b0 && b_bit === 1'b0, "R10", "bits in reset", int'({a_bit, b_bit}), 0);
      @(posedge clk); #1; rst_n = 1;

      // Vector table: divisors 2..9, both edge settings, several skews (R1, R2, R4..R7, R9)
      for (int v = 0; v < NVEC; v++) begin
         int a0, b0;
         start(int'(VEC[v][12:5]), VEC[v][4], int'(VEC[v][3:0]), 1'b1, 1'b1);
         a0 = a_cnt; b0 = b_cnt;
         repeat (10 * n_cur) @(posedge clk);
         #1; mon_on = 0;
         chk(a_cnt - a0 >= 8, "R9", "lane A strobes per run", a_cnt - a0, 9);
         chk(b_cnt - b0 >= 8, "R9", "lane B strobes per run", b_cnt - b0, 9);
      end

      // R3: clock parks low with both enables off
      en_a = 0; en_b = 0;
      repeat (2) @(negedge clk);
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         chk(mic_clk === 1'b0, "R3", "idle clock", int'(mic_clk), 0);
      end

      // R8: only lane A enabled, lane B must stay silent and hold its bit
      begin
         logic hold; int bc, ac;
         start(2, 1'b0, 1, 1'b1, 1'b0);
         hold = b_bit; bc = b_cnt; ac = a_cnt;
         repeat (40) @(posedge clk);
         #1; mon_on = 0;
         chk(b_cnt == bc, "R8", "lane B strobes while off", b_cnt - bc, 0);
         chk(b_bit === hold, "R8", "lane B bit held", int'(b_bit), int'(hold));
         chk(a_cnt - ac >= 9, "R8", "lane A runs alone", a_cnt - ac, 10);
         // only lane B enabled, with channels swapped
         start(3, 1'b1, 0, 1'b0, 1'b1);
         hold = a_bit; ac = a_cnt;
         repeat (40) @(posedge clk);
         #1; mon_on = 0;
         chk(a_cnt == ac, "R8", "lane A strobes while off", a_cnt - ac, 0);
         chk(a_bit === hold, "R8", "lane A bit held", int'(a_bit), int'(hold));
      end

      // R10: reset while running
      start(5, 1'b0, 0, 1'b1, 1'b1);
      repeat (9) @(posedge clk);
      #1; mon_on = 0; rst_n = 0;
      @(negedge clk);
      chk(mic_clk === 1'b0 && a_vld === 1'b0 && b_vld === 1'b0 && a_bit === 1'b0 && b_bit === 1'b0,
          "R10", "outputs after mid-run reset", int'({mic_clk, a_vld, b_vld, a_bit, b_bit}), 0);
      @(posedge clk); #1; rst_n = 1; en_a = 0; en_b = 0;
      repeat (4) @(posedge clk);
      finish_run();
   end

endmodule